// File: doc/BRIEF.md
# Buffered Continuous SPI Master

This block is a clocked-serial master that moves fixed-length frames out on a data-out pin and in from a data-in pin, with no idle gap between frames. A single data register sits in front of the shift register as a one-entry holding buffer. Software writes the next transmit byte into that register while the current frame is still shifting. When that frame ends, the byte moves into the shift register and the next frame begins on the following clock. The same register returns each received byte once its frame completes.

An interrupt line can be set to fire at one of two points, and the choice may change while frames are running. In buffer-empty timing the line pulses each time the holding buffer hands its byte to the shift register, which tells software it can write the next byte. In transfer-end timing the line pulses when a frame ends, which is how the last frame of a stream is reported. Start and stop strobes enable and disable the channel. A busy flag and a buffer-full flag show the transfer state.

Top module: `spi_buf_master`

## Requirements
- R1: During and right after reset, `sck` is 1, `so` is 1, and `busy`, `buf_full`, `irq` and `rd_data` are all 0.
- R2: The serial clock idles high. Each bit lasts CLK_DIV system cycles: CLK_DIV/2 cycles low, then CLK_DIV/2 cycles high. `so` carries the frame MSB first and changes only when `sck` falls. `si` is sampled on the system clock edge at which `sck` rises. `so` rests at 1 whenever `busy` is 0.
- R3: A write (`wr_en` high for one cycle) sets `buf_full` from the next cycle on. `buf_full` clears on the edge at which the byte moves into the shift register, unless another write arrives on that same edge.
- R4: A write while `buf_full` is 1 replaces the pending byte. Only the last byte written is sent.
- R5: If a byte is pending when a frame's last bit ends, and no stop has been requested, the next frame's first falling edge of `sck` follows at once. `busy` never drops between the two frames.
- R6: `rd_data` always shows the data register. After a write it returns the written byte, and reading has no effect on the transfer. When a frame ends, the received byte replaces the register contents, except when a byte stays pending because a stop prevents it from moving.
- R7: With `irq_mode` = 0 (buffer-empty timing), `irq` is high for exactly one cycle, on the cycle after each transfer of the holding buffer into the shift register.
- R8: With `irq_mode` = 1 (transfer-end timing), `irq` is high for one cycle, on the cycle after a frame's last bit ends. The timing used for a frame is the `irq_mode` value seen on the edge at which that frame's last bit starts.
- R9: `busy` rises on the cycle after the first byte moves into the shift register. It stays high across back-to-back frames and falls on the cycle after the last frame ends with no byte moving in.
- R10: A `stop` pulse during a frame lets that frame finish, then disables the channel. `sck` returns to idle-high and any pending byte stays in the buffer. A `stop` pulse while idle disables the channel at once, and later writes do not start a frame.
- R11: A byte written while the channel is disabled waits. A `start` with an empty buffer waits for the first write, and the first frame begins two cycles after whichever of the start or the write comes last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the data register |
| wr_data | input | BITS | Transmit byte to buffer |
| rd_data | output | BITS | Current data register contents |
| start | input | 1 | Enable strobe |
| stop | input | 1 | Disable strobe; takes effect after the current frame |
| irq_mode | input | 1 | 0 = buffer-empty interrupt timing, 1 = transfer-end timing |
| sck | output | 1 | Serial clock, idle high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| irq | output | 1 | One-cycle interrupt pulse |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Holding buffer has a byte that has not yet been sent |

## Verification
The assertions assume that `wr_en`, `start` and `stop` are single-cycle strobes driven synchronously to `clk`. They also assume that `si` settles before the sampling edge, and that reset is applied before any strobe is used. The stimulus meets these assumptions by driving every input on the falling edge of `clk`, holding each strobe for exactly one cycle, and changing `si` only on falling edges from a bench-side pseudo-random source. Writes are placed both just after a buffer transfer and in back-to-back pairs, so that overwrites and a write landing on a frame boundary both occur.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

    // Interrupt timing selection
    typedef enum logic {
        IRQ_ON_EMPTY = 1'b0,
        IRQ_ON_END   = 1'b1
    } irq_sel_e;

    // Single-cycle events produced by the bit timer
    typedef struct packed {
        logic sample;      // sck rises on this edge: capture si
        logic bit_end;     // last cycle of a bit period
        logic frame_end;   // last cycle of the frame's final bit
        logic last_start;  // edge that starts the frame's final bit
    } tick_t;

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/spi_buf_timing.sv
module spi_buf_timing
    import spi_buf_pkg::*;
#(
    parameter int unsigned BITS    = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output logic  sck,
    output tick_t tick
);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned DW   = cnt_w(CLK_DIV);
    localparam int unsigned BW   = cnt_w(BITS);

    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;

    always_comb begin
        tick.sample     = run && (div_q == DW'(HALF - 1));
        tick.bit_end    = run && (div_q == DW'(CLK_DIV - 1));
        tick.frame_end  = tick.bit_end && (bit_q == BW'(BITS - 1));
        tick.last_start = tick.bit_end && (bit_q == BW'(BITS - 2));
        sck             = !(run && (div_q < DW'(HALF)));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            bit_q <= '0;
        end else if (tick.bit_end) begin
            div_q <= '0;
            bit_q <= (bit_q == BW'(BITS - 1)) ? '0 : bit_q + BW'(1);
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

endmodule

// File: rtl/spi_buf_shift.sv
module spi_buf_shift #(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            shift,
    input  logic            sample,
    input  logic            si,
    output logic            so_bit,
    output logic [BITS-1:0] rx_val
);
    logic [BITS-1:0] tx_q;
    logic [BITS-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)
                tx_q <= load_val;
            else if (shift)
                tx_q <= {tx_q[BITS-2:0], 1'b0};
            if (sample)
                rx_q <= {rx_q[BITS-2:0], si};
        end
    end

    assign so_bit = tx_q[BITS-1];
    assign rx_val = rx_q;

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
    import spi_buf_pkg::*;
#(
    parameter int unsigned BITS    = 8,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [BITS-1:0] wr_data,
    output logic [BITS-1:0] rd_data,
    input  logic            start,
    input  logic            stop,
    input  logic            irq_mode,
    output logic            sck,
    output logic            so,
    input  logic            si,
    output logic            irq,
    output logic            busy,
    output logic            buf_full
);
    tick_t           tick;
    irq_sel_e        mode_in;
    irq_sel_e        frame_mode_q;
    logic            enabled_q, shifting_q, stop_pend_q, buf_full_q, irq_q;
    logic [BITS-1:0] data_q;
    logic [BITS-1:0] rx_val;
    logic            so_bit;
    logic            stop_now, load_idle, load_cont, load, irq_next;

    assign mode_in   = irq_sel_e'(irq_mode);
    assign stop_now  = stop || stop_pend_q;
    assign load_idle = enabled_q && !shifting_q && buf_full_q && !stop;
    assign load_cont = tick.frame_end && buf_full_q && !stop_now;
    assign load      = load_idle || load_cont;
    assign irq_next  = (load_idle && mode_in == IRQ_ON_EMPTY)
                    || (load_cont && frame_mode_q == IRQ_ON_EMPTY)
                    || (tick.frame_end && frame_mode_q == IRQ_ON_END);

    spi_buf_timing #(.BITS(BITS), .CLK_DIV(CLK_DIV)) u_timing (
        .clk  (clk),
        .rst  (rst),
        .run  (shifting_q),
        .sck  (sck),
        .tick (tick)
    );

    spi_buf_shift #(.BITS(BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (data_q),
        .shift    (tick.bit_end),
        .sample   (tick.sample),
        .si       (si),
        .so_bit   (so_bit),
        .rx_val   (rx_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled_q    <= 1'b0;
            shifting_q   <= 1'b0;
            stop_pend_q  <= 1'b0;
            buf_full_q   <= 1'b0;
            irq_q        <= 1'b0;
            data_q       <= '0;
            frame_mode_q <= IRQ_ON_EMPTY;
        end else begin
            irq_q <= irq_next;

            if (stop && !shifting_q)
                enabled_q <= 1'b0;
            else if (tick.frame_end && stop_now)
                enabled_q <= 1'b0;
            else if (start)
                enabled_q <= 1'b1;

            if (tick.frame_end)
                stop_pend_q <= 1'b0;
            else if (stop && shifting_q)
                stop_pend_q <= 1'b1;

            if (load)
                shifting_q <= 1'b1;
            else if (tick.frame_end)
                shifting_q <= 1'b0;

            if (wr_en)
                buf_full_q <= 1'b1;
            else if (load)
                buf_full_q <= 1'b0;

            // write wins; otherwise received byte replaces the register
            // unless a byte is left pending by a stop
            if (wr_en)
                data_q <= wr_data;
            else if (tick.frame_end && !(buf_full_q && !load))
                data_q <= rx_val;

            if (tick.last_start)
                frame_mode_q <= mode_in;
        end
    end

    assign rd_data  = data_q;
    assign busy     = shifting_q;
    assign buf_full = buf_full_q;
    assign irq      = irq_q;
    assign so       = shifting_q ? so_bit : 1'b1;

    // R2: both serial lines rest high when no frame runs
    p_idle_lines_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck && so));

    // R4: a write always leaves the written byte pending and visible
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (buf_full && rd_data == $past(wr_data)));

    // R5: a pending byte at frame end starts the next low phase at once
    p_no_gap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick.frame_end && buf_full && !stop && !stop_pend_q) |=> (busy && !sck));

    // R7: interrupt is a single-cycle pulse
    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R10: stop while idle keeps the channel idle
    p_stop_halts_r10: assert property (@(posedge clk) disable iff (rst)
        (stop && !busy) |=> !busy);

endmodule

// File: tb/spi_buf_master_test.sv
module spi_buf_master_test;
    localparam int BITS  = 8;
    localparam int DIV   = 4;
    localparam int HALF  = DIV / 2;
    localparam int FRAME = BITS * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       irq_mode = 1'b0;
    logic       si;
    logic [7:0] rd_data;
    logic       sck, so, irq, busy, buf_full;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_buf_master #(.BITS(BITS), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .start(start), .stop(stop), .irq_mode(irq_mode),
        .sck(sck), .so(so), .si(si), .irq(irq), .busy(busy), .buf_full(buf_full)
    );

    // pseudo-random serial input, changes on falling clk edges only
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk)
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign si = lfsr[0];

    // ---------------- behavioural reference model ----------------
    bit         m_en, m_act, m_stopreq, m_lmode, m_irq;
    int         m_pos;
    logic [7:0] m_tx, m_rx, m_reg;
    logic [7:0] m_pend[$];

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_act = 0; m_stopreq = 0; m_lmode = 0; m_irq = 0;
            m_pos = 0; m_tx = 0; m_rx = 0; m_reg = 0;
            m_pend.delete();
        end else begin
            bit irq_n;
            irq_n = 0;
            if (m_act) begin
                if (m_pos == FRAME - 1) begin
                    bit stopping, had, loaded;
                    stopping = stop || m_stopreq;
                    had = (m_pend.size() != 0);
                    loaded = 0;
                    if (m_lmode) irq_n = 1;
                    if (had && !stopping) begin
                        m_tx = m_pend.pop_front();
                        loaded = 1;
                        if (!m_lmode) irq_n = 1;
                    end
                    if (!(had && !loaded)) m_reg = m_rx;
                    if (!loaded) begin
                        m_act = 0;
                        if (stopping) m_en = 0;
                    end
                    m_stopreq = 0;
                    m_pos = 0;
                end else begin
                    if (m_pos % DIV == HALF - 1) m_rx = {m_rx[6:0], si};
                    if (m_pos == (BITS - 1) * DIV - 1) m_lmode = irq_mode;
                    if (stop) m_stopreq = 1;
                    m_pos++;
                end
            end else begin
                if (stop) m_en = 0;
                else if (m_en && m_pend.size() != 0) begin
                    m_tx = m_pend.pop_front();
                    m_act = 1;
                    m_pos = 0;
                    if (!irq_mode) irq_n = 1;
                end else if (start) m_en = 1;
            end
            if (wr_en) begin
                m_pend.delete();
                m_pend.push_back(wr_data);
                m_reg = wr_data;
            end
            m_irq = irq_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit e_sck, e_so;
            e_sck = !(m_act && (m_pos % DIV) < HALF);
            e_so  = m_act ? m_tx[BITS - 1 - m_pos / DIV] : 1'b1;
            check(sck == e_sck, "R2", "sck", sck, e_sck);
            check(so == e_so, "R2", "so", so, e_so);
            check(busy == m_act, "R9", "busy", busy, m_act);
            check(buf_full == (m_pend.size() != 0), "R3", "buf_full", buf_full, m_pend.size() != 0);
            check(irq == m_irq, "R7/R8", "irq", irq, m_irq);
            check(rd_data == m_reg, "R6", "rd_data", rd_data, m_reg);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    int gaps;
    task automatic feed(input int n, input logic [7:0] seed, input bit toggle);
        int cyc = 0;
        for (int k = 0; k < n; k++) begin
            while (buf_full) begin
                if (!busy) gaps++;
                @(negedge clk);
                cyc++;
                if (toggle && cyc % 13 == 0) irq_mode = ~irq_mode;
            end
            write_byte(seed + 8'(k * 37));
        end
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (busy && lim < 2000) begin @(negedge clk); lim++; end
        repeat (2) @(negedge clk);
    endtask

    // ---------------- scenario ----------------
    initial begin
        repeat (3) @(negedge clk);
        check(sck == 1 && so == 1 && busy == 0 && buf_full == 0 && irq == 0 && rd_data == 0,
              "R1", "reset state", {sck, so, busy, buf_full, irq}, 5'b11000);
        rst = 1'b0;
        @(negedge clk);
        check(sck == 1 && busy == 0 && rd_data == 0, "R1", "after reset", {sck, busy}, 2'b10);

        // R11: write while disabled waits
        write_byte(8'hA5);
        repeat (10) @(negedge clk);
        check(busy == 0, "R11", "busy while disabled", busy, 0);
        check(rd_data == 8'hA5, "R6", "pending byte readable", rd_data, 8'hA5);
        pulse_start();
        @(negedge clk);
        check(busy == 1, "R11", "frame starts after start", busy, 1);

        // R5: continuous stream in buffer-empty timing, last frame in transfer-end timing
        gaps = 0;
        irq_mode = 1'b0;
        feed(5, 8'h3C, 1'b0);
        irq_mode = 1'b1;
        check(gaps == 0, "R5", "idle cycles inside stream", gaps, 0);
        wait_idle();
        check(busy == 0 && buf_full == 0, "R9", "idle after stream", busy, 0);

        // R4: overwrite while pending
        irq_mode = 1'b0;
        write_byte(8'h11);
        repeat (3) @(negedge clk);
        write_byte(8'h22);
        write_byte(8'h33);
        check(rd_data == 8'h33 && buf_full == 1, "R4", "overwrite", rd_data, 8'h33);
        write_byte(8'h44);
        write_byte(8'h55);
        check(rd_data == 8'h55, "R4", "overwrite second", rd_data, 8'h55);
        wait_idle();

        // R8: interrupt timing toggling during a stream
        write_byte(8'h96);
        @(negedge clk);
        feed(6, 8'h5A, 1'b1);
        wait_idle();

        // R10: stop mid-frame with a byte pending
        irq_mode = 1'b1;
        write_byte(8'hC7);
        repeat (4) @(negedge clk);
        write_byte(8'hE1);
        pulse_stop();
        wait_idle();
        check(busy == 0 && buf_full == 1, "R10", "pending kept after stop", buf_full, 1);
        check(sck == 1, "R10", "sck idle after stop", sck, 1);
        repeat (20) @(negedge clk);
        check(busy == 0, "R10", "no restart after stop", busy, 0);

        // R10: stop while idle keeps channel off; restart sends pending byte
        pulse_start();
        pulse_stop();
        repeat (10) @(negedge clk);
        check(busy == 0, "R10", "idle stop", busy, 0);
        pulse_start();
        @(negedge clk);
        check(busy == 1, "R11", "restart with pending", busy, 1);
        wait_idle();

        // R11: start with empty buffer waits for write
        repeat (20) @(negedge clk);
        check(busy == 0, "R11", "start with empty buffer", busy, 0);
        irq_mode = 1'b0;
        write_byte(8'h0F);
        @(negedge clk);
        check(busy == 1, "R11", "first write launches frame", busy, 1);
        wait_idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule